// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is a 32-bit up-counting timer driven through a small synchronous register bus. The count advances on every clock or, when the divider is enabled, once every 2^(ptv+1) clocks. When it steps past all ones, the counter either reloads from a load register and keeps running, or clears to zero and stops. A compare unit flags the step on which the count reaches a programmed match value.

Software can write the counter directly. It can also write a trigger register, which copies the load value into the counter. Overflow and match are exported as one-clock strobes for neighbouring output and capture logic, and the full control word is exported as well. An event unit collects overflow, match and an external capture event. It latches the enabled ones into a status register, holds a level interrupt while any status bit is set, and emits a one-clock wakeup pulse for events that are wakeup-enabled.

Register word addresses: 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 status (write 1 to clear), 6 interrupt enable, 7 wakeup enable. Read data appears on `bus_rdata` one clock after a read strobe.

Top module: `upt_timer`

## Requirements
- R1: After reset the control word, counter, load, match, status and both enable masks are zero, and `irq_o` and `wake_o` are low.
- R2: While control bit 0 (run) is set and control bit 5 (divider enable) is clear, the counter increments by one on every clock, starting the second clock after the control write. With run clear the counter holds.
- R3: With bit 5 set, the counter increments once every 2^(ptv+1) clocks, where ptv is control bits 4:2.
- R4: On the increment from 0xFFFFFFFF with control bit 1 (auto-reload) set, the counter takes the load value and keeps running, and `ovf_o` is high for exactly that clock.
- R5: On that increment with bit 1 clear, the counter becomes zero and the run bit clears. A control read then shows bit 0 low.
- R6: With control bit 6 (compare enable) set, `mat_o` pulses for one clock when the counter steps to the match value. With bit 6 clear it never pulses.
- R7: Status bits are match = bit 0, overflow = bit 1 and capture (`capt_evt_i`) = bit 2. An event sets its status bit one clock after the event only if the same bit of the interrupt-enable mask is set. `irq_o` is high while any status bit is set.
- R8: Writing status with a 1 in a bit clears that bit, and `irq_o` drops once all bits are zero.
- R9: An event whose bit is set in the wakeup-enable mask produces a one-clock `wake_o` pulse, one clock after the event, whatever the interrupt-enable mask holds.
- R10: Any write to the trigger register loads the counter from the load register. A trigger read returns 0xFFFFFFFF.
- R11: A counter write wins over an increment in the same clock, and every control write restarts the divider from zero.
- R12: The interrupt-enable and wakeup-enable registers keep only bits 2:0 and read back zero above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (3) | Register word address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | CNT_W (32) | Read data, valid one clock after `bus_re` |
| capt_evt_i | input | 1 | One-clock capture event from the capture unit |
| ctrl_o | output | 15 | Current control word for the neighbouring units |
| ovf_o | output | 1 | One-clock overflow strobe |
| mat_o | output | 1 | One-clock match strobe |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | One-clock wakeup pulse |

## Verification
The count function is run over several divider settings: off, ptv 0, 1 and 2. Each run stops the timer after a fixed window, so a wrong divisor or a wrong first-tick offset shows up as a different final count. Overflow is reached from values just below all ones, once with reload and once without. This separates the reload path from stop-and-clear, and shows whether the strobe, the status latch and the wakeup each land on the predicted clock. Match is tried with compare enabled and with compare disabled. The interrupt and wakeup masks are set to disjoint patterns, so a status bit latched from the wrong mask is caught. A rewrite of the control word while the timer runs and a counter write during counting expose the two priority rules.

// File: rtl/upt_pkg.sv
package upt_pkg;
  localparam int PTV_W  = 3;
  localparam int PSC_W  = 1 << PTV_W;
  localparam int CTRL_W = 15;
  localparam int EV_W   = 3;

  localparam int EV_MAT = 0;
  localparam int EV_OVF = 1;
  localparam int EV_CAP = 2;

  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_COUNT = 3'd1,
    RG_LOAD  = 3'd2,
    RG_TRIG  = 3'd3,
    RG_MATCH = 3'd4,
    RG_STAT  = 3'd5,
    RG_IEN   = 3'd6,
    RG_WEN   = 3'd7
  } reg_sel_e;

  // Field order is fixed because the neighbouring units decode ctrl_o.
  typedef struct packed {
    logic       pin_dir;
    logic       capt_second;
    logic       toggle_sel;
    logic [1:0] trig_mode;
    logic [1:0] capt_mode;
    logic       idle_level;
    logic       cmp_en;
    logic       div_en;
    logic [PTV_W-1:0] ptv;
    logic       reload;
    logic       run;
  } ctrl_t;

  // Low-bit mask that the divider counter must fill before a tick.
  function automatic logic [PSC_W-1:0] div_mask(input logic en,
                                                input logic [PTV_W-1:0] ptv);
    logic [PSC_W:0] span;
    span = ((PSC_W+1)'(1) << (32'(ptv) + 1)) - (PSC_W+1)'(1);
    return en ? span[PSC_W-1:0] : '0;
  endfunction

  function automatic logic div_due(input logic [PSC_W-1:0] cnt,
                                   input logic [PSC_W-1:0] mask);
    return (cnt & mask) == mask;
  endfunction
endpackage

// File: rtl/upt_prescaler.sv
module upt_prescaler
  import upt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             div_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] mask;

  assign mask = div_mask(div_en, ptv);
  assign tick = run && div_due(div_q, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (run)     div_q <= div_q + PSC_W'(1);
    else              div_q <= '0;
  end
endmodule

// File: rtl/upt_counter.sv
module upt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_trig,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  input  logic             cmp_en,
  input  logic             reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_stb,
  output logic             mat_stb,
  output logic             stop_req
);
  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic rl,
                                            input logic [CNT_W-1:0] ld);
    if (cur == TOP) return rl ? ld : '0;
    return cur + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;
  logic             mat_d;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = 1'b0;
    mat_d = 1'b0;
    if (wr_cnt) begin
      cnt_d = wdata;
    end else if (wr_trig) begin
      cnt_d = load_val;
    end else if (tick) begin
      ovf_d = (cnt_q == TOP);
      cnt_d = step(cnt_q, reload, load_val);
      mat_d = cmp_en && (cnt_d == match_val);
    end
  end

  assign stop_req = ovf_d && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ovf_stb <= 1'b0;
      mat_stb <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ovf_stb <= ovf_d;
      mat_stb <= mat_d;
    end
  end
endmodule

// File: rtl/upt_event_unit.sv
module upt_event_unit #(
  parameter int N_EV = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev,
  input  logic [N_EV-1:0] irq_en,
  input  logic [N_EV-1:0] wake_en,
  input  logic            clr_wr,
  input  logic [N_EV-1:0] clr_mask,
  output logic [N_EV-1:0] status,
  output logic            irq,
  output logic            wake
);
  logic [N_EV-1:0] keep;

  assign keep = clr_wr ? ~clr_mask : '1;
  assign irq  = |status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      wake   <= 1'b0;
    end else begin
      status <= (status & keep) | (ev & irq_en);
      wake   <= |(ev & wake_en);
    end
  end
endmodule

// File: rtl/upt_timer.sv
module upt_timer
  import upt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              capt_evt_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ovf_o,
  output logic              mat_o,
  output logic              irq_o,
  output logic              wake_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q, match_q, cnt_q, rd_mux;
  logic [EV_W-1:0]  ien_q, wen_q, status, ev;
  logic             wr_ctrl, wr_cnt, wr_load, wr_trig, wr_match, wr_stat, wr_ien, wr_wen;
  logic             tick, ovf_stb, mat_stb, stop_req;

  assign wr_ctrl  = bus_we && (bus_addr == ADDR_W'(RG_CTRL));
  assign wr_cnt   = bus_we && (bus_addr == ADDR_W'(RG_COUNT));
  assign wr_load  = bus_we && (bus_addr == ADDR_W'(RG_LOAD));
  assign wr_trig  = bus_we && (bus_addr == ADDR_W'(RG_TRIG));
  assign wr_match = bus_we && (bus_addr == ADDR_W'(RG_MATCH));
  assign wr_stat  = bus_we && (bus_addr == ADDR_W'(RG_STAT));
  assign wr_ien   = bus_we && (bus_addr == ADDR_W'(RG_IEN));
  assign wr_wen   = bus_we && (bus_addr == ADDR_W'(RG_WEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      load_q  <= '0;
      match_q <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
    end else begin
      if (wr_ctrl)       ctrl_q     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (stop_req) ctrl_q.run <= 1'b0;
      if (wr_load)  load_q  <= bus_wdata;
      if (wr_match) match_q <= bus_wdata;
      if (wr_ien)   ien_q   <= bus_wdata[EV_W-1:0];
      if (wr_wen)   wen_q   <= bus_wdata[EV_W-1:0];
    end
  end

  upt_prescaler u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(wr_ctrl),
    .run    (ctrl_q.run),
    .div_en (ctrl_q.div_en),
    .ptv    (ctrl_q.ptv),
    .tick   (tick)
  );

  upt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_cnt   (wr_cnt),
    .wr_trig  (wr_trig),
    .wdata    (bus_wdata),
    .load_val (load_q),
    .match_val(match_q),
    .cmp_en   (ctrl_q.cmp_en),
    .reload   (ctrl_q.reload),
    .cnt_q    (cnt_q),
    .ovf_stb  (ovf_stb),
    .mat_stb  (mat_stb),
    .stop_req (stop_req)
  );

  always_comb begin
    ev         = '0;
    ev[EV_MAT] = mat_stb;
    ev[EV_OVF] = ovf_stb;
    ev[EV_CAP] = capt_evt_i;
  end

  upt_event_unit #(.N_EV(EV_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev),
    .irq_en  (ien_q),
    .wake_en (wen_q),
    .clr_wr  (wr_stat),
    .clr_mask(bus_wdata[EV_W-1:0]),
    .status  (status),
    .irq     (irq_o),
    .wake    (wake_o)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(RG_CTRL):  rd_mux = CNT_W'(ctrl_q);
      ADDR_W'(RG_COUNT): rd_mux = cnt_q;
      ADDR_W'(RG_LOAD):  rd_mux = load_q;
      ADDR_W'(RG_TRIG):  rd_mux = '1;
      ADDR_W'(RG_MATCH): rd_mux = match_q;
      ADDR_W'(RG_STAT):  rd_mux = CNT_W'(status);
      ADDR_W'(RG_IEN):   rd_mux = CNT_W'(ien_q);
      ADDR_W'(RG_WEN):   rd_mux = CNT_W'(wen_q);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  assign ctrl_o = ctrl_q;
  assign ovf_o  = ovf_stb;
  assign mat_o  = mat_stb;
endmodule

// File: rtl/upt_checker.sv
module upt_checker
  import upt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] match_val,
  input logic             reload,
  input logic             run,
  input logic             cmp_en,
  input logic             wr_cnt,
  input logic             wr_trig,
  input logic             wr_ctrl,
  input logic             ovf_stb,
  input logic             mat_stb,
  input logic [EV_W-1:0]  ev,
  input logic [EV_W-1:0]  irq_en,
  input logic [EV_W-1:0]  wake_en,
  input logic [EV_W-1:0]  status,
  input logic             clr_wr,
  input logic [EV_W-1:0]  clr_mask,
  input logic             irq,
  input logic             wake
);
  // R4 / R5: the value after an overflow is the old load value or zero
  assert_ovf_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_stb |-> (cnt == ($past(reload) ? $past(load_val) : '0)))
    else $error("overflow left the wrong counter value");

  assert_ovf_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_stb && !$past(reload) && !$past(wr_ctrl)) |-> !run)
    else $error("run bit survived a non-reload overflow");

  assert_match_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mat_stb |-> ((cnt == $past(match_val)) && $past(cmp_en)))
    else $error("match strobe without compare hit");

  assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt && !wr_trig) |=> $stable(cnt))
    else $error("stopped counter moved");

  for (genvar k = 0; k < EV_W; k++) begin : g_stat
    assert_status_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[k]) |-> $past(irq_en[k]))
      else $error("status bit set while its enable was clear");
  end

  assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((status & ~clr_mask) == '0) && ((ev & irq_en) == '0)) |=> !irq)
    else $error("interrupt stayed high after full clear");

  assert_wake_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(|(ev & wake_en)))
    else $error("wakeup pulse without an enabled event");
endmodule

bind upt_timer upt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt      (cnt_q),
  .load_val (load_q),
  .match_val(match_q),
  .reload   (ctrl_q.reload),
  .run      (ctrl_q.run),
  .cmp_en   (ctrl_q.cmp_en),
  .wr_cnt   (wr_cnt),
  .wr_trig  (wr_trig),
  .wr_ctrl  (wr_ctrl),
  .ovf_stb  (ovf_stb),
  .mat_stb  (mat_stb),
  .ev       (ev),
  .irq_en   (ien_q),
  .wake_en  (wen_q),
  .status   (status),
  .clr_wr   (wr_stat),
  .clr_mask (bus_wdata[EV_W-1:0]),
  .irq      (irq_o),
  .wake     (wake_o)
);

// File: tb/upt_timer_bench.sv
module upt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        capt_evt_i = 1'b0;
  logic [14:0] ctrl_o;
  logic        ovf_o, mat_o, irq_o, wake_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_LOAD = 3'd2, A_TRIG = 3'd3,
                         A_MAT = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6, A_WEN = 3'd7;

  always #5 clk = ~clk;

  upt_timer u_upt_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .capt_evt_i(capt_evt_i), .ctrl_o(ctrl_o), .ovf_o(ovf_o), .mat_o(mat_o),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue a read and push the expected item to the scoreboard.
  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    bus_re = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) rd_pend <= bus_re;

  // Monitor: pop and compare each read result as it appears.
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq low", {31'd0, irq_o}, 32'd0);
    chk("R1 wake low", {31'd0, wake_o}, 32'd0);
    rd(A_CTRL, 32'd0, "R1 ctrl");
    rd(A_CNT, 32'd0, "R1 count");
    rd(A_STAT, 32'd0, "R1 status");
    rd(A_IEN, 32'd0, "R1 irq enable");

    // R12 enable masks keep three bits
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, 32'd7, "R12 irq enable mask");
    wr(A_WEN, 32'h0000_00FA);
    rd(A_WEN, 32'd2, "R12 wake enable mask");
    wr(A_IEN, 32'd0);
    wr(A_WEN, 32'd0);

    // R2 every-clock count: stop lands 8 increments later
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h1);
    idle(6);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd8, "R2 count without divider");
    idle(3);
    rd(A_CNT, 32'd8, "R2 hold while stopped");

    // R3 divider settings
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h21);
    idle(6);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd4, "R3 ptv0 divide by 2");
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h25);
    idle(6);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd2, "R3 ptv1 divide by 4");
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h29);
    idle(14);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd2, "R3 ptv2 divide by 8");

    // R11 control rewrite restarts the divider
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h25);
    wr(A_CTRL, 32'h25);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd0, "R11 divider restart");

    // R10 trigger
    wr(A_LOAD, 32'h0000_1234);
    wr(A_TRIG, 32'h0000_DEAD);
    rd(A_CNT, 32'h0000_1234, "R10 trigger load");
    rd(A_TRIG, 32'hFFFF_FFFF, "R10 trigger read");

    // R11 counter write beats the increment
    wr(A_CTRL, 32'h1);
    wr(A_CNT, 32'h0000_0100);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'h0000_0102, "R11 write priority");

    // R4 / R7 reload overflow, overflow interrupt only
    wr(A_IEN, 32'd2);
    wr(A_LOAD, 32'h0000_0010);
    wr(A_CNT, 32'hFFFF_FFFD);
    wr(A_CTRL, 32'h3);
    idle(2);
    chk("R4 no early overflow", {31'd0, ovf_o}, 32'd0);
    idle(1);
    chk("R4 overflow strobe", {31'd0, ovf_o}, 32'd1);
    idle(1);
    chk("R4 strobe one clock", {31'd0, ovf_o}, 32'd0);
    chk("R7 irq after enabled overflow", {31'd0, irq_o}, 32'd1);
    chk("R9 no wake when disabled", {31'd0, wake_o}, 32'd0);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'h0000_0013, "R4 reload and keep running");
    rd(A_STAT, 32'd2, "R7 overflow status");

    // R8 clear
    wr(A_STAT, 32'd2);
    chk("R8 irq drops", {31'd0, irq_o}, 32'd0);

    // R5 / R9 non-reload overflow, wakeup only
    wr(A_IEN, 32'd0);
    wr(A_WEN, 32'd2);
    wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1);
    idle(2);
    chk("R5 overflow strobe", {31'd0, ovf_o}, 32'd1);
    idle(1);
    chk("R9 wake pulse", {31'd0, wake_o}, 32'd1);
    chk("R7 no irq when disabled", {31'd0, irq_o}, 32'd0);
    idle(1);
    chk("R9 wake one clock", {31'd0, wake_o}, 32'd0);
    idle(2);
    chk("R5 run cleared on ctrl_o", {17'd0, ctrl_o}, 32'd0);
    rd(A_CNT, 32'd0, "R5 counter cleared and held");
    rd(A_CTRL, 32'd0, "R5 run bit reads low");
    rd(A_STAT, 32'd0, "R7 disabled event not latched");

    // R6 match, then capture and partial clears
    wr(A_WEN, 32'd0);
    wr(A_IEN, 32'd5);
    wr(A_CNT, 32'd0);
    wr(A_MAT, 32'd5);
    wr(A_CTRL, 32'h41);
    idle(4);
    chk("R6 no early match", {31'd0, mat_o}, 32'd0);
    idle(1);
    chk("R6 match strobe", {31'd0, mat_o}, 32'd1);
    idle(1);
    chk("R6 match one clock", {31'd0, mat_o}, 32'd0);
    chk("R7 irq after match", {31'd0, irq_o}, 32'd1);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 32'd8, "R6 count after match run");
    @(negedge clk);
    capt_evt_i = 1'b1;
    @(negedge clk);
    capt_evt_i = 1'b0;
    rd(A_STAT, 32'd5, "R7 match and capture status");
    wr(A_STAT, 32'd1);
    chk("R8 irq stays with a bit left", {31'd0, irq_o}, 32'd1);
    rd(A_STAT, 32'd4, "R8 partial clear");
    wr(A_STAT, 32'd4);
    chk("R8 irq drops at zero", {31'd0, irq_o}, 32'd0);
    rd(A_STAT, 32'd0, "R8 status empty");

    // R6 compare disabled
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h1);
    idle(5);
    chk("R6 no match when disabled", {31'd0, mat_o}, 32'd0);
    wr(A_CTRL, 32'h0);
    rd(A_STAT, 32'd0, "R6 no match status when disabled");

    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule